// File: doc/BRIEF.md
# Cache Access Issue Unit

This block turns pipeline memory commands into requests on a cache port that is allowed to refuse them. An initiate command (fetch, read or write) builds one request. The request carries a direction, an address, a byte size and store data. The unit offers the request on the port. If the port refuses it, the unit keeps the request and offers it again only when the port pulses its retry strobe. Once the port accepts it, the unit waits for the response. A later complete command polls the slot. It finishes when the access has come back, and otherwise answers with a stall so that the stage holds.

The unit also tracks load-linked and store-conditional pairs with one link register. The link register holds a valid bit and an address. A locked read arms it when its response arrives. A write from another agent to that address, seen on the snoop input, disarms it. A locked write is checked against the link register and consumes it. A locked write that fails sends nothing to the port and still completes, returning 0.

Port rules for back-pressure: `req_valid` is high for exactly one cycle per offer, and a transfer happens in a cycle where both `req_valid` and `req_ready` are high. After a refused offer, the unit keeps `req_valid` low until a cycle with `port_retry` high, and it re-offers in that cycle. The command side is plain: a command is consumed in the cycle `cmd_valid` is high, and the status outputs in that same cycle give its outcome.

Top module: `cache_issue_unit`

## Requirements
- R1: An initiate-fetch command (op 0) in an idle unit offers, in the same cycle, a read (`req_write`=0) of 4 bytes at the command address.
- R2: Initiate-read (op 2) and initiate-write (op 3) offer a read or a write of `cmd_size` bytes. A size other than 1, 2, 4 or 8 raises `cmd_size_err` in that cycle, and nothing is offered or stored.
- R3: After a refused offer, `req_valid` stays low until `port_retry` is high. In that cycle the same request is offered again. If it is refused again, the unit keeps waiting for the next retry.
- R4: After an accepted offer, the unit waits for `rsp_valid`, and it captures `rsp_data` from the first response.
- R5: A complete command (op 1 fetch, op 4 read, op 5 write) raises `cmd_done` only once the access has finished. Otherwise it raises `cmd_stall`. After `cmd_done` the unit is idle. At most one of `cmd_done`, `cmd_stall`, `cmd_busy` and `cmd_size_err` is high.
- R6: An initiate command while the slot is occupied (waiting for retry, waiting for response, or finished but not yet completed) raises `cmd_busy` and is not offered.
- R7: The response to a locked read sets the link register to the read's address.
- R8: A locked write whose address matches a valid link is offered normally. On completion `sc_ok` is 1, and the link is consumed.
- R9: A locked write with no matching link offers nothing. Its complete command is done in the next cycle with `sc_ok`=0 and `res_data`=0.
- R10: A snoop to the linked address clears the link. A snoop to any other address leaves it in place.
- R11: In the `cmd_done` cycle, `res_data` holds the response data of a read or fetch, or the store data of a write, zero-extended from the access size.
- R12: Opcodes 6 and 7 have no effect, and a `rsp_valid` while no response is awaited is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 init fetch, 1 complete fetch, 2 init read, 3 init write, 4 complete read, 5 complete write |
| cmd_addr | input | AW | Access address |
| cmd_size | input | SW | Byte size for read and write |
| cmd_locked | input | 1 | Load-linked or store-conditional flag |
| cmd_wdata | input | DW | Store data |
| cmd_done | output | 1 | Complete command finished |
| cmd_stall | output | 1 | Complete command not yet finished |
| cmd_busy | output | 1 | Initiate refused, slot occupied |
| cmd_size_err | output | 1 | Initiate refused, bad size |
| res_data | output | DW | Zero-extended result, valid with cmd_done |
| sc_ok | output | 1 | Locked write succeeded, valid with cmd_done |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Port accepts the offer |
| req_write | output | 1 | Request is a write |
| req_addr | output | AW | Request address |
| req_size | output | SW | Request byte size |
| req_wdata | output | DW | Request store data |
| port_retry | input | 1 | Port may now take the refused request |
| rsp_valid | input | 1 | Response present |
| rsp_data | input | DW | Response data |
| snoop_valid | input | 1 | Another agent writes memory |
| snoop_addr | input | AW | Address of that write |

## Verification
The bench targets four areas. The first is the refused-offer path: a double refusal followed by acceptance, where a unit that re-offers without a strobe, or changes the request, shows a stray or altered `req_valid`. The second is polling a complete command before, during and after the response cycle, where a unit that finishes too early raises `cmd_done` with stale data. The third is the link register: a consumed link, a snoop to a neighbouring address and a snoop to the linked address, where a unit that mismatches them sends a failed store-conditional or blocks a good one. The fourth covers the size masks, the ignored opcodes and a stray response, which a careless design would turn into wrong result bytes or a phantom completion.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [2:0] {
    OP_INIT_FETCH = 3'd0,
    OP_DONE_FETCH = 3'd1,
    OP_INIT_READ  = 3'd2,
    OP_INIT_WRITE = 3'd3,
    OP_DONE_READ  = 3'd4,
    OP_DONE_WRITE = 3'd5
  } cu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RETRY = 2'd1,
    ST_WRSP  = 2'd2,
    ST_DONE  = 2'd3
  } cu_state_e;

  function automatic logic size_legal(input logic [3:0] sz);
    return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
  endfunction
endpackage

// File: rtl/cu_zext.sv
module cu_zext #(
  parameter int DW = 64,
  parameter int SW = 4
) (
  input  logic [SW-1:0] size,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dout[8*b +: 8] = (b < int'(size)) ? din[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/cu_link_reg.sv
module cu_link_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic          consume,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          link_valid,
  output logic [AW-1:0] link_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_addr  <= '0;
    end else if (set_en) begin
      link_valid <= 1'b1;
      link_addr  <= set_addr;
    end else if (consume || (snoop_valid && snoop_addr == link_addr)) begin
      link_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cu_issue_fsm.sv
module cu_issue_fsm
  import cu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic      size_ok,
  input  logic      locked,
  input  logic      link_hit,
  input  logic      req_ready,
  input  logic      port_retry,
  input  logic      rsp_valid,
  output cu_state_e state,
  output logic      accept_init,
  output logic      send_new,
  output logic      send_old,
  output logic      capture_rsp,
  output logic      sc_attempt,
  output logic      sc_fail,
  output logic      done,
  output logic      stall,
  output logic      busy,
  output logic      size_err
);
  logic is_init, is_comp, sized, bad_size, idle;
  cu_state_e state_d;

  always_comb begin
    is_init = cmd_valid && (cmd_op == OP_INIT_FETCH || cmd_op == OP_INIT_READ ||
                            cmd_op == OP_INIT_WRITE);
    is_comp = cmd_valid && (cmd_op == OP_DONE_FETCH || cmd_op == OP_DONE_READ ||
                            cmd_op == OP_DONE_WRITE);
    sized       = (cmd_op == OP_INIT_READ) || (cmd_op == OP_INIT_WRITE);
    bad_size    = sized && !size_ok;
    idle        = (state == ST_IDLE);
    busy        = is_init && !idle;
    size_err    = is_init && idle && bad_size;
    accept_init = is_init && idle && !bad_size;
    sc_attempt  = accept_init && (cmd_op == OP_INIT_WRITE) && locked;
    sc_fail     = sc_attempt && !link_hit;
    send_new    = accept_init && !sc_fail;
    send_old    = (state == ST_RETRY) && port_retry;
    capture_rsp = (state == ST_WRSP) && rsp_valid;
    done        = is_comp && (state == ST_DONE);
    stall       = is_comp && (state != ST_DONE);
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (sc_fail)       state_d = ST_DONE;
        else if (send_new) state_d = req_ready ? ST_WRSP : ST_RETRY;
      end
      ST_RETRY: if (send_old && req_ready) state_d = ST_WRSP;
      ST_WRSP:  if (capture_rsp) state_d = ST_DONE;
      ST_DONE:  if (done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/cache_issue_unit.sv
module cache_issue_unit
  import cu_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int SW         = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [SW-1:0] cmd_size,
  input  logic          cmd_locked,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_done,
  output logic          cmd_stall,
  output logic          cmd_busy,
  output logic          cmd_size_err,
  output logic [DW-1:0] res_data,
  output logic          sc_ok,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [SW-1:0] req_size,
  output logic [DW-1:0] req_wdata,
  input  logic          port_retry,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr
);
  localparam logic [SW-1:0] FETCH_SZ = SW'(INSN_BYTES);

  cu_state_e     state_q;
  logic          accept_init, send_new, send_old, capture_rsp;
  logic          sc_attempt, sc_fail, link_valid, link_hit;
  logic [AW-1:0] link_addr;
  logic          new_write;
  logic [SW-1:0] new_size;

  // held request
  logic          h_write, h_locked, h_sc_pass;
  logic [AW-1:0] h_addr;
  logic [SW-1:0] h_size;
  logic [DW-1:0] h_wdata, h_rdata;
  logic [DW-1:0] wr_ext, rd_ext;

  assign new_write = (cmd_op == OP_INIT_WRITE);
  assign new_size  = (cmd_op == OP_INIT_FETCH) ? FETCH_SZ : cmd_size;
  assign link_hit  = link_valid && (link_addr == cmd_addr);

  cu_issue_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .size_ok     (size_legal(4'(cmd_size))),
    .locked      (cmd_locked),
    .link_hit    (link_hit),
    .req_ready   (req_ready),
    .port_retry  (port_retry),
    .rsp_valid   (rsp_valid),
    .state       (state_q),
    .accept_init (accept_init),
    .send_new    (send_new),
    .send_old    (send_old),
    .capture_rsp (capture_rsp),
    .sc_attempt  (sc_attempt),
    .sc_fail     (sc_fail),
    .done        (cmd_done),
    .stall       (cmd_stall),
    .busy        (cmd_busy),
    .size_err    (cmd_size_err)
  );

  cu_link_reg #(.AW(AW)) u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (capture_rsp && !h_write && h_locked),
    .set_addr    (h_addr),
    .consume     (sc_attempt),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .link_valid  (link_valid),
    .link_addr   (link_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_write   <= 1'b0;
      h_locked  <= 1'b0;
      h_sc_pass <= 1'b0;
      h_addr    <= '0;
      h_size    <= '0;
      h_wdata   <= '0;
      h_rdata   <= '0;
    end else begin
      if (accept_init) begin
        h_write   <= new_write;
        h_locked  <= cmd_locked && (cmd_op != OP_INIT_FETCH);
        h_sc_pass <= sc_attempt && !sc_fail;
        h_addr    <= cmd_addr;
        h_size    <= new_size;
        h_wdata   <= cmd_wdata;
      end
      if (capture_rsp) h_rdata <= rsp_data;
    end
  end

  always_comb begin
    req_valid = send_new || send_old;
    if (send_new) begin
      req_write = new_write;
      req_addr  = cmd_addr;
      req_size  = new_size;
      req_wdata = cmd_wdata;
    end else begin
      req_write = h_write;
      req_addr  = h_addr;
      req_size  = h_size;
      req_wdata = h_wdata;
    end
  end

  cu_zext #(.DW(DW), .SW(SW)) u_wr_ext (.size(h_size), .din(h_wdata), .dout(wr_ext));
  cu_zext #(.DW(DW), .SW(SW)) u_rd_ext (.size(h_size), .din(h_rdata), .dout(rd_ext));

  always_comb begin
    if (h_write) res_data = (h_locked && !h_sc_pass) ? '0 : wr_ext;
    else         res_data = rd_ext;
    sc_ok = h_write && h_locked && h_sc_pass;
  end
endmodule

// File: rtl/cache_issue_unit_chk.sv
module cache_issue_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       req_valid,
  input logic       req_ready,
  input logic       port_retry,
  input logic       cmd_done,
  input logic       cmd_stall,
  input logic       cmd_busy,
  input logic       cmd_size_err
);
  localparam logic [1:0] S_IDLE = 2'd0, S_RETRY = 2'd1;

  a_r3_quiet_until_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RETRY && !port_retry) |-> !req_valid);
  a_r3_refusal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (st == S_RETRY));
  a_r4_single_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
  a_r6_busy_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && !port_retry) |-> !req_valid);
  a_r5_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_done, cmd_stall, cmd_busy, cmd_size_err}));
  a_r5_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (st == S_IDLE));
  a_r2_bad_size_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_size_err |-> !req_valid);
endmodule

bind cache_issue_unit cache_issue_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st           (state_q),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .port_retry   (port_retry),
  .cmd_done     (cmd_done),
  .cmd_stall    (cmd_stall),
  .cmd_busy     (cmd_busy),
  .cmd_size_err (cmd_size_err)
);

// File: tb/cache_issue_unit_tb_top.sv
module cache_issue_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_locked = 0;
  logic [2:0]  cmd_op = 0;
  logic [31:0] cmd_addr = 0;
  logic [3:0]  cmd_size = 0;
  logic [63:0] cmd_wdata = 0;
  logic        cmd_done, cmd_stall, cmd_busy, cmd_size_err, sc_ok;
  logic [63:0] res_data;
  logic        req_valid, req_write;
  logic        req_ready = 0, port_retry = 0, rsp_valid = 0, snoop_valid = 0;
  logic [31:0] req_addr, snoop_addr = 0;
  logic [3:0]  req_size;
  logic [63:0] req_wdata, rsp_data = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cache_issue_unit dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    cmd_valid = 0; cmd_locked = 0; cmd_op = 0; port_retry = 0;
    rsp_valid = 0; snoop_valid = 0; req_ready = 1;
  endtask

  // drive a command at the negedge, leave sampling point 1 ns later
  task automatic cmd(input logic [2:0] op, input logic [31:0] a, input logic [3:0] sz,
                     input logic lk, input logic [63:0] wd);
    @(negedge clk); quiet();
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_size = sz; cmd_locked = lk;
    cmd_wdata = wd; #1;
  endtask

  task automatic respond(input logic [63:0] d);
    @(negedge clk); quiet(); rsp_valid = 1; rsp_data = d; #1;
  endtask

  task automatic finish_op(input logic [2:0] op, input logic [63:0] exp,
                           input logic exp_sc, input string tag);
    cmd(op, 0, 0, 0, 0);
    check(cmd_done === 1'b1, {tag, " done"}, cmd_done, 1);
    check(res_data === exp, {tag, " data"}, res_data, exp);
    check(sc_ok === exp_sc, {tag, " sc_ok"}, sc_ok, exp_sc);
  endtask

  task automatic t_reset();
    @(negedge clk); quiet(); #1;
    check(req_valid === 0 && cmd_done === 0 && cmd_busy === 0, "R5 reset idle", req_valid, 0);
    cmd(1, 0, 0, 0, 0);
    check(cmd_stall === 1'b1, "R5 complete while idle stalls", cmd_stall, 1);
  endtask

  task automatic t_fetch();
    cmd(0, 32'h1000, 4'd8, 0, 0);
    check(req_valid === 1 && req_write === 0, "R1 fetch offered as read", req_write, 0);
    check(req_size === 4'd4, "R1 fetch size", req_size, 4);
    check(req_addr === 32'h1000, "R1 fetch addr", req_addr, 32'h1000);
    cmd(1, 0, 0, 0, 0);
    check(cmd_stall === 1, "R5 poll before response", cmd_stall, 1);
    respond(64'hAABBCCDD_11223344);
    finish_op(1, 64'h11223344, 0, "R4 R11 fetch result");
  endtask

  task automatic t_retry();
    cmd(2, 32'h2000, 4'd2, 0, 0); req_ready = 0; #0;
    check(req_valid === 1 && req_size === 4'd2, "R2 read offer size", req_size, 2);
    @(negedge clk); quiet(); #1;
    check(req_valid === 0, "R3 no offer without strobe", req_valid, 0);
    cmd(0, 32'h3000, 0, 0, 0);
    check(cmd_busy === 1 && req_valid === 0, "R6 busy while held", cmd_busy, 1);
    @(negedge clk); quiet(); port_retry = 1; req_ready = 0; #1;
    check(req_valid === 1 && req_addr === 32'h2000, "R3 re-offer on strobe", req_addr, 32'h2000);
    @(negedge clk); quiet(); #1;
    check(req_valid === 0, "R3 second refusal waits", req_valid, 0);
    @(negedge clk); quiet(); port_retry = 1; #1;
    check(req_valid === 1 && req_size === 4'd2 && req_write === 0, "R3 same request", req_size, 2);
    @(negedge clk); quiet(); rsp_valid = 1; rsp_data = 64'h5555_6666_7777_ABCD;
    cmd_valid = 1; cmd_op = 4; #1;
    check(cmd_stall === 1, "R5 poll in response cycle", cmd_stall, 1);
    cmd(0, 32'h3000, 0, 0, 0);
    check(cmd_busy === 1 && req_valid === 0, "R6 busy when finished", cmd_busy, 1);
    finish_op(4, 64'hABCD, 0, "R4 R11 read half");
  endtask

  task automatic t_sizes();
    cmd(3, 32'h4000, 4'd3, 0, 64'h1);
    check(cmd_size_err === 1 && req_valid === 0, "R2 size 3 refused", cmd_size_err, 1);
    cmd(2, 32'h4000, 4'd0, 0, 0);
    check(cmd_size_err === 1 && req_valid === 0, "R2 size 0 refused", cmd_size_err, 1);
    cmd(3, 32'h4008, 4'd8, 0, 64'hFEDC_BA98_7654_3210);
    check(req_valid === 1 && req_write === 1 && req_size === 4'd8, "R2 write size 8", req_size, 8);
    check(req_wdata === 64'hFEDC_BA98_7654_3210, "R2 write data", req_wdata, 64'hFEDC_BA98_7654_3210);
    respond(0);
    finish_op(5, 64'hFEDC_BA98_7654_3210, 0, "R11 write 8");
    cmd(3, 32'h4010, 4'd1, 0, 64'hFFFF_FFFF_FFFF_FF5A);
    respond(0);
    finish_op(5, 64'h5A, 0, "R11 write 1");
    cmd(2, 32'h4018, 4'd4, 0, 0);
    respond(64'h9999_8888_7777_6666);
    finish_op(4, 64'h7777_6666, 0, "R11 read 4");
  endtask

  task automatic t_llsc();
    cmd(2, 32'h5000, 4'd4, 1, 0);
    respond(64'h42);
    finish_op(4, 64'h42, 0, "R7 load-linked");
    cmd(3, 32'h5000, 4'd4, 1, 64'hCAFE);
    check(req_valid === 1 && req_write === 1, "R7 R8 linked store offered", req_valid, 1);
    respond(0);
    finish_op(5, 64'hCAFE, 1, "R8 store-conditional ok");
    cmd(3, 32'h5000, 4'd4, 1, 64'hBEEF);
    check(req_valid === 0, "R8 R9 link consumed, no offer", req_valid, 0);
    finish_op(5, 64'h0, 0, "R9 failed store-conditional");
  endtask

  task automatic t_snoop();
    cmd(2, 32'h6000, 4'd8, 1, 0);
    respond(1);
    finish_op(4, 64'h1, 0, "R7 link arm");
    @(negedge clk); quiet(); snoop_valid = 1; snoop_addr = 32'h6008; #1;
    cmd(3, 32'h6000, 4'd2, 1, 64'h1234);
    check(req_valid === 1, "R10 other snoop keeps link", req_valid, 1);
    respond(0);
    finish_op(5, 64'h1234, 1, "R10 store after other snoop");
    cmd(2, 32'h6000, 4'd8, 1, 0);
    respond(2);
    finish_op(4, 64'h2, 0, "R7 link re-arm");
    @(negedge clk); quiet(); snoop_valid = 1; snoop_addr = 32'h6000; #1;
    cmd(3, 32'h6000, 4'd2, 1, 64'h1234);
    check(req_valid === 0, "R10 snoop clears link", req_valid, 0);
    finish_op(5, 64'h0, 0, "R10 store fails after snoop");
  endtask

  task automatic t_ignore();
    cmd(6, 32'h7000, 4'd4, 0, 0);
    check(req_valid === 0 && cmd_done === 0 && cmd_stall === 0 && cmd_busy === 0,
          "R12 op 6 no effect", req_valid, 0);
    cmd(7, 32'h7000, 4'd4, 0, 0);
    check(req_valid === 0 && cmd_stall === 0, "R12 op 7 no effect", req_valid, 0);
    respond(64'hDEAD);
    cmd(5, 0, 0, 0, 0);
    check(cmd_stall === 1, "R12 stray response gives no completion", cmd_stall, 1);
    cmd(2, 32'h7000, 4'd2, 0, 0);
    check(req_valid === 1 && cmd_busy === 0, "R12 unit still idle", req_valid, 1);
    respond(64'h0000_0000_0000_1357);
    finish_op(4, 64'h1357, 0, "R12 R4 read after stray");
  endtask

  initial begin
    quiet();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_fetch();
    t_retry();
    t_sizes();
    t_llsc();
    t_snoop();
    t_ignore();
    @(negedge clk); quiet();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule